// File: doc/BRIEF.md
# Three-Lane Framed Serial-to-Parallel Receiver

This block takes three serial data lanes plus a forwarded frame-clock lane, all sampled on one bit clock that runs seven times faster than the frame rate. It watches the sampled frame-clock lane for its fixed seven-sample shape to find where each frame ends. Each data lane is shifted into its own seven-bit register. Once per frame the three registers are copied into one 21-bit output word.

Each new word comes with a one-cycle valid pulse. A frame-rate output clock is also produced in the bit-clock domain. It rises one bit-clock cycle after each word update.

An active-low shutdown input clears every register at once. After it is released, the block must find the frame alignment again before it presents any data. The block only ever outputs complete frames. Nothing is emitted while frame alignment is in doubt.

Top module: `tri_lane_deser`

## Requirements
- R1: Lane 0 lands in word bits 6..0, lane 1 in bits 13..7 and lane 2 in bits 20..14 of `word_out`.
- R2: On every lane, the first bit sampled in a frame becomes the top bit of that lane's slice, and the seventh bit sampled becomes the bottom bit.
- R3: A frame ends on the bit-clock edge where the last seven frame-clock samples, oldest first, read 1,1,0,0,0,1,1. `locked` rises on the edge that samples the end of the second such frame, provided that end lies exactly seven cycles after the end of the first.
- R4: While locked, each frame that ends on its expected edge is copied to `word_out` one bit-clock cycle after its last bit is sampled. In that same cycle `word_valid` pulses for exactly one cycle. `word_valid` is never high while `locked` is low, and `word_out` holds its value in every other cycle.
- R5: While locked, `oclk_out` is high for 4 of every 7 bit-clock cycles and rises in the cycle after each `word_valid` pulse. While unlocked, `oclk_out` is low.
- R6: While locked, if an expected frame end is reached and the frame-clock samples do not show the pattern, `locked` falls on that edge and that frame is not output. Relocking needs two aligned pattern matches again.
- R7: While `shdn_n` is low, all state is cleared at once and held. `word_out` reads zero, and `word_valid`, `oclk_out` and `locked` read low. This holds even if traffic keeps arriving.
- R8: After `shdn_n` is released, no word is output until lock has been rebuilt from two fresh aligned frames. This works at any bit phase of the incoming stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock |
| shdn_n | input | 1 | Active-low shutdown; clears all state asynchronously |
| lane_in | input | 3 | Sampled serial data lanes; bit i is lane i |
| fclk_in | input | 1 | Sampled forwarded frame-clock lane |
| word_out | output | 21 | Parallel word assembled from the three lanes |
| word_valid | output | 1 | One-cycle pulse marking a fresh word |
| oclk_out | output | 1 | Frame-rate output clock, registered on `clk` |
| locked | output | 1 | Frame alignment established |

## Verification
The bench builds the block with its default parameters:
- three lanes of seven bits each;
- the 1100011 frame-clock shape;
- a two-frame lock threshold;
- an output clock that is high for four cycles.

With these values, the complete 21-bit lane map and the per-lane bit order can be checked against lane-distinct and asymmetric words. A single corrupted frame is enough to show loss of lock followed by a two-frame relock. A stream restarted at an odd bit offset after shutdown shows that alignment does not depend on reset phase. Because the frame period is seven cycles, the duty-cycle window and every lock transition fall within a few dozen cycles.

// File: rtl/deser_pkg.sv
package deser_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int              FRAME_BITS_DEF  = 7;
    localparam int              LANES_DEF       = 3;
    localparam int              LOCK_FRAMES_DEF = 2;
    localparam int              OCLK_HIGH_DEF   = 4;
    localparam logic [6:0]      FCLK_PAT_DEF    = 7'b1100011;

    typedef enum logic {
        TRK_HUNT   = 1'b0,
        TRK_LOCKED = 1'b1
    } trk_mode_e;
endpackage

// File: rtl/deser_lane_shift.sv
module deser_lane_shift #(
    parameter int FRAME_BITS = 7
) (
    input  logic                  clk,
    input  logic                  shdn_n,
    input  logic                  bit_in,
    output logic [FRAME_BITS-1:0] shift_q
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [FRAME_BITS-1:0] sr;
    } lane_s;

    lane_s lane_d, lane_q;

    // Earliest bit drifts toward the top of the register.
    always_comb begin
        lane_d    = lane_q;
        lane_d.sr = {lane_q.sr[FRAME_BITS-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge shdn_n) begin
        if (!shdn_n) lane_q <= '0;
        else         lane_q <= lane_d;
    end

    assign shift_q = lane_q.sr;
endmodule

// File: rtl/deser_frame_tracker.sv
module deser_frame_tracker
    import deser_pkg::*;
#(
    parameter int                    FRAME_BITS  = FRAME_BITS_DEF,
    parameter logic [FRAME_BITS-1:0] FCLK_PAT    = FCLK_PAT_DEF,
    parameter int                    LOCK_FRAMES = LOCK_FRAMES_DEF,
    localparam int                   PW          = $clog2(FRAME_BITS),
    localparam int                   MW          = $clog2(LOCK_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          shdn_n,
    input  logic          fclk_in,
    output logic          frame_done,
    output logic          locked,
    output logic [PW-1:0] phase
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [PW-1:0] LAST_PH = PW'(FRAME_BITS - 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] hist;
        logic [PW-1:0]         phase;
        logic [MW-1:0]         match;
        trk_mode_e             mode;
        logic                  done;
    } trk_s;

    trk_s trk_d, trk_q;
    logic pat_hit;
    logic at_slot;

    always_comb begin
        trk_d      = trk_q;
        trk_d.hist = {trk_q.hist[FRAME_BITS-2:0], fclk_in};
        pat_hit    = (trk_d.hist == FCLK_PAT);
        at_slot    = (trk_q.phase == LAST_PH);
        trk_d.phase = at_slot ? '0 : trk_q.phase + PW'(1);
        trk_d.done  = 1'b0;

        if (trk_q.mode == TRK_HUNT) begin
            if (pat_hit) begin
                // Re-anchor the frame counter on every candidate boundary.
                trk_d.phase = '0;
                trk_d.match = (at_slot && trk_q.match != '0) ?
                              trk_q.match + MW'(1) : MW'(1);
                if (trk_d.match == MW'(LOCK_FRAMES)) begin
                    trk_d.mode = TRK_LOCKED;
                end
            end else if (at_slot) begin
                trk_d.match = '0;
            end
        end else begin
            if (at_slot) begin
                if (pat_hit) begin
                    trk_d.done = 1'b1;
                end else begin
                    trk_d.mode  = TRK_HUNT;
                    trk_d.match = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge shdn_n) begin
        if (!shdn_n) trk_q <= '0;
        else         trk_q <= trk_d;
    end

    assign frame_done = trk_q.done;
    assign locked     = (trk_q.mode == TRK_LOCKED);
    assign phase      = trk_q.phase;
endmodule

// File: rtl/tri_lane_deser.sv
module tri_lane_deser
    import deser_pkg::*;
#(
    parameter int                    LANES       = LANES_DEF,
    parameter int                    FRAME_BITS  = FRAME_BITS_DEF,
    parameter logic [FRAME_BITS-1:0] FCLK_PAT    = FCLK_PAT_DEF,
    parameter int                    LOCK_FRAMES = LOCK_FRAMES_DEF,
    parameter int                    OCLK_HIGH   = OCLK_HIGH_DEF,
    localparam int                   WORD_W      = LANES * FRAME_BITS,
    localparam int                   PW          = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              shdn_n,
    input  logic [LANES-1:0]  lane_in,
    input  logic              fclk_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              oclk_out,
    output logic              locked
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [WORD_W-1:0] lanes_flat;
    logic              frame_done;
    logic [PW-1:0]     phase;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            deser_lane_shift #(
                .FRAME_BITS(FRAME_BITS)
            ) u_shift (
                .clk     (clk),
                .shdn_n  (shdn_n),
                .bit_in  (lane_in[l]),
                .shift_q (lanes_flat[l*FRAME_BITS +: FRAME_BITS])
            );
        end
    endgenerate

    deser_frame_tracker #(
        .FRAME_BITS  (FRAME_BITS),
        .FCLK_PAT    (FCLK_PAT),
        .LOCK_FRAMES (LOCK_FRAMES)
    ) u_track (
        .clk        (clk),
        .shdn_n     (shdn_n),
        .fclk_in    (fclk_in),
        .frame_done (frame_done),
        .locked     (locked),
        .phase      (phase)
    );

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              oclk;
    } out_s;

    out_s out_d, out_q;

    // Capture one cycle after the boundary, straight from the lane registers.
    always_comb begin
        out_d       = out_q;
        out_d.valid = frame_done;
        if (frame_done) begin
            out_d.word = lanes_flat;
        end
        out_d.oclk = locked && (phase >= PW'(1)) && (phase <= PW'(OCLK_HIGH));
    end

    always_ff @(posedge clk or negedge shdn_n) begin
        if (!shdn_n) out_q <= '0;
        else         out_q <= out_d;
    end

    assign word_out   = out_q.word;
    assign word_valid = out_q.valid;
    assign oclk_out   = out_q.oclk;
endmodule

// File: rtl/deser_chk.sv
module deser_chk #(
    parameter int WORD_W = 21
) (
    input logic              clk,
    input logic              shdn_n,
    input logic [WORD_W-1:0] word_out,
    input logic              word_valid,
    input logic              oclk_out,
    input logic              locked
);
    timeunit 1ns;
    timeprecision 1ps;

    // R4
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!shdn_n)
        word_valid |-> locked);

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (!shdn_n)
        word_valid |=> !word_valid);

    // R4
    word_hold_chk: assert property (@(posedge clk) disable iff (!shdn_n)
        !word_valid |-> $stable(word_out));

    // R5
    oclk_after_valid_chk: assert property (@(posedge clk) disable iff (!shdn_n)
        word_valid |=> $rose(oclk_out));

    // R5
    oclk_idle_unlocked_chk: assert property (@(posedge clk) disable iff (!shdn_n)
        !locked |-> !oclk_out);

    // R7
    shutdown_clear_chk: assert property (@(posedge clk)
        !shdn_n |=> (word_out == '0 && !word_valid && !oclk_out && !locked));
endmodule

bind tri_lane_deser deser_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .shdn_n     (shdn_n),
    .word_out   (word_out),
    .word_valid (word_valid),
    .oclk_out   (oclk_out),
    .locked     (locked)
);

// File: tb/tri_lane_deser_test.sv
module tri_lane_deser_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [6:0] FPAT = 7'b1100011;

    typedef struct packed {
        logic [20:0] word;
        logic        ok;
        logic        lk;
    } vec_t;

    localparam vec_t VEC [11] = '{
        '{21'h1FFFFF, 1'b1, 1'b0},
        '{21'h000000, 1'b1, 1'b1},
        '{21'h00007F, 1'b1, 1'b1},
        '{21'h003F80, 1'b1, 1'b1},
        '{21'h1FC000, 1'b1, 1'b1},
        '{21'h0C1832, 1'b1, 1'b1},
        '{21'h155555, 1'b0, 1'b0},
        '{21'h0AAAAA, 1'b1, 1'b0},
        '{21'h1E0F03, 1'b1, 1'b1},
        '{21'h012345, 1'b1, 1'b1},
        '{21'h1A2B3C, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        shdn_n = 1'b0;
    logic [2:0]  lanes = '0;
    logic        fclk = 1'b0;
    logic [20:0] word_out;
    logic        word_valid;
    logic        oclk_out;
    logic        locked;

    int checks = 0;
    int fails  = 0;
    int vcnt   = 0;
    int ohi    = 0;
    logic prev_valid = 1'b0;
    logic prev_oclk  = 1'b0;

    always #2 clk = ~clk;

    tri_lane_deser uut (
        .clk        (clk),
        .shdn_n     (shdn_n),
        .lane_in    (lanes),
        .fclk_in    (fclk),
        .word_out   (word_out),
        .word_valid (word_valid),
        .oclk_out   (oclk_out),
        .locked     (locked)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic observe();
        if (word_valid) begin
            vcnt++;
            chk(locked == 1'b1, "R4 valid only while locked", 32'(locked), 32'd1);
        end
        if (prev_valid)
            chk(oclk_out && !prev_oclk, "R5 oclk rises after valid", {30'd0, prev_oclk, oclk_out}, 32'd1);
        if (!locked)
            chk(!oclk_out, "R5 oclk low while unlocked", 32'(oclk_out), 32'd0);
        if (oclk_out) ohi++;
        prev_valid = word_valid;
        prev_oclk  = oclk_out;
    endtask

    task automatic tick(input logic [2:0] d, input logic f);
        @(negedge clk);
        observe();
        lanes = d;
        fclk  = f;
    endtask

    task automatic send_frame(input logic [20:0] w, input logic ok);
        for (int b = 6; b >= 0; b--)
            tick({w[14+b], w[7+b], w[b]}, ok ? FPAT[b] : 1'b0);
    endtask

    function automatic bit produces(input int i);
        return (i > 0) && VEC[i-1].lk && VEC[i].ok;
    endfunction

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL R4 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int exp_v;
        int ohi_mark;
        int vstart;
        logic [20:0] last_w;
        exp_v  = 0;
        last_w = '0;
        ohi_mark = 0;

        repeat (3) @(negedge clk);
        // R7 reset state
        chk(word_out == '0, "R7 reset word", 32'(word_out), 32'd0);
        chk({word_valid, oclk_out, locked} == 3'b000, "R7 reset flags",
            {29'd0, word_valid, oclk_out, locked}, 32'd0);
        @(negedge clk);
        shdn_n = 1'b1;

        // Table walk: lock, steady traffic, one lost frame, relock.
        for (int f = 0; f < 11; f++) begin
            send_frame(VEC[f].word, VEC[f].ok);
            settle();
            chk(locked == VEC[f].lk,
                VEC[f].ok ? "R3 lock state after frame" : "R6 lock drops on missing pattern",
                32'(locked), 32'(VEC[f].lk));
            if (f > 0) begin
                if (produces(f - 1)) begin
                    exp_v++;
                    last_w = VEC[f-1].word;
                    chk(vcnt == exp_v, "R4 one valid per locked frame", 32'(vcnt), 32'(exp_v));
                    chk(word_out == last_w, "R1/R2 lane slices and bit order", 32'(word_out), 32'(last_w));
                end else begin
                    chk(vcnt == exp_v, "R6 no valid for unaligned frame", 32'(vcnt), 32'(exp_v));
                    chk(word_out == last_w, "R6 word held without update", 32'(word_out), 32'(last_w));
                end
            end
            if (f == 2) ohi_mark = ohi;
            if (f == 4) chk(ohi - ohi_mark == 8, "R5 oclk high 4 of 7", 32'(ohi - ohi_mark), 32'd8);
        end

        // Flush the last table frame's output.
        tick(3'b000, 1'b1);
        tick(3'b000, 1'b1);
        tick(3'b000, 1'b0);
        settle();
        exp_v++;
        chk(vcnt == exp_v, "R4 final frame valid", 32'(vcnt), 32'(exp_v));
        chk(word_out == VEC[10].word, "R1/R2 final frame word", 32'(word_out), 32'(VEC[10].word));

        // R7 shutdown clears at once and holds under traffic.
        @(negedge clk);
        shdn_n = 1'b0;
        #1;
        chk(word_out == '0, "R7 shutdown clears word", 32'(word_out), 32'd0);
        chk({word_valid, oclk_out, locked} == 3'b000, "R7 shutdown clears flags",
            {29'd0, word_valid, oclk_out, locked}, 32'd0);
        send_frame(21'h1FFFFF, 1'b1);
        send_frame(21'h1FFFFF, 1'b1);
        settle();
        chk(locked == 1'b0, "R7 no lock while shut down", 32'(locked), 32'd0);
        chk(word_out == '0, "R7 word held at zero", 32'(word_out), 32'd0);

        // R8 relock after release, stream at a shifted bit phase.
        @(negedge clk);
        shdn_n = 1'b1;
        tick(3'b000, 1'b0);
        tick(3'b000, 1'b0);
        tick(3'b000, 1'b0);
        vstart = vcnt;
        send_frame(21'h0ABCDE, 1'b1);
        settle();
        chk(locked == 1'b0, "R8 one frame is not enough", 32'(locked), 32'd0);
        send_frame(21'h111111, 1'b1);
        settle();
        chk(locked == 1'b1, "R8 relock after two frames", 32'(locked), 32'd1);
        chk(vcnt == vstart, "R8 no data before relock", 32'(vcnt), 32'(vstart));
        chk(word_out == '0, "R8 word still cleared", 32'(word_out), 32'd0);
        send_frame(21'h15A5A5, 1'b1);
        send_frame(21'h062C4E, 1'b1);
        settle();
        chk(vcnt == vstart + 1, "R8 first word after relock", 32'(vcnt), 32'(vstart + 1));
        chk(word_out == 21'h15A5A5, "R8 first word value", 32'(word_out), 32'h15A5A5);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule